// File: doc/BRIEF.md
# Display Interrupt Hub with Half-Word Write Masks

This block gathers sixteen single-cycle event pulses from a display pipeline, keeps each one latched until software acknowledges it, and drives one level-sensitive interrupt line towards the processor. Software reaches it through four 32-bit word registers: an enable register, an acknowledge register, a filtered pending view and an unfiltered pending view.

Writes to the enable and acknowledge registers carry a per-bit selector in the upper half-word. Only the lower bits whose selector bit is 1 are touched. Software can therefore turn a single source on or off, or acknowledge a single source, without first reading the register back. A handler reads the filtered view and writes that value, with the same pattern in the selector half, to the acknowledge register. This retires exactly the events it has seen. An event that arrives during the acknowledge is not lost.

Source positions are fixed: 0 frame start, 1 new frame start, 2 repeated scan-out address, 3 and 4 line flags, 5 bus error, 6 to 9 layer 0 to 3 underrun, 10 cursor underrun, 11 post-processing buffer empty, 12 field frame start, 13 hold acknowledged, 14 translation fault, 15 fetch done.

Top module: `dispirq_hub`

## Requirements
- R1: While reset is applied and after it is released, the enable bits and the latched pending bits are all 0 and `irq_o` is 0.
- R2: A write to the enable register (byte offset 0x280) changes only the enable bits i whose selector bit wdata[16+i] is 1; each such bit takes wdata[i]. All other enable bits keep their value.
- R3: A write to the acknowledge register (byte offset 0x284) clears pending bit i when both wdata[16+i] and wdata[i] are 1. A bit whose selector is 0, or whose value bit is 0, is left unchanged.
- R4: A pulse on `src_evt[i]` sets pending bit i at the next clock edge whether source i is enabled or not. The unfiltered view (byte offset 0x28C) shows all pending bits in [15:0].
- R5: The filtered view (byte offset 0x288) reads the pending bits ANDed with the enable bits in [15:0], with zero in [31:16].
- R6: `irq_o` is a register. It is 1 in the cycle after a clock edge at which some filtered bit was 1, and 0 in the cycle after an edge at which none was. It deasserts one edge after the last filtered bit is cleared or disabled.
- R7: When an event and an acknowledge of the same bit meet at the same clock edge, the event wins and the bit stays pending.
- R8: Reading the enable register or the acknowledge register returns the enable bits in [15:0] and zero in [31:16].
- R9: Reads of any other offset return zero. Writes to any other offset, including the two status views, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside on the clock |
| reg_we | input | 1 | Write strobe for the addressed register, one cycle per write |
| reg_addr | input | ADDR_W (12) | Byte offset of the accessed register |
| reg_wdata | input | 32 | Write data: selector in [31:16], values in [15:0] |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from current state |
| src_evt | input | NSRC (16) | Event pulses, one bit per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that `reg_addr` and `reg_we` are stable across each clock edge and that a write strobe lasts exactly one cycle per intended write. They also assume event pulses are presented as plain levels sampled at the edge, with no relation to bus activity required. The stimulus changes every input only on the falling clock edge. It raises the write strobe for one vector at a time and sets event bits freely, including in the same cycle as an acknowledge of the same bit. Reads are taken just after the rising edge, when the combinational read path already reflects the updated state.

// File: rtl/dispirq_pkg.sv
package dispirq_pkg;

  // Byte offsets of the four word registers; software depends on them.
  localparam logic [11:0] OFF_ENABLE = 12'h280;
  localparam logic [11:0] OFF_ACK    = 12'h284;
  localparam logic [11:0] OFF_FILT   = 12'h288;
  localparam logic [11:0] OFF_RAW    = 12'h28C;

  // Register selected by the current address.
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_ACK    = 3'd2,
    SEL_FILT   = 3'd3,
    SEL_RAW    = 3'd4
  } reg_sel_e;

  // Source positions in every 16-bit view.
  localparam int unsigned SRC_FRAME_START  = 0;
  localparam int unsigned SRC_NEW_FRAME    = 1;
  localparam int unsigned SRC_ADDR_REPEAT  = 2;
  localparam int unsigned SRC_LINE_A       = 3;
  localparam int unsigned SRC_LINE_B       = 4;
  localparam int unsigned SRC_BUS_ERR      = 5;
  localparam int unsigned SRC_LAYER0_UNDER = 6;
  localparam int unsigned SRC_CURSOR_UNDER = 10;
  localparam int unsigned SRC_POST_EMPTY   = 11;
  localparam int unsigned SRC_FIELD_START  = 12;
  localparam int unsigned SRC_HOLD_ACK     = 13;
  localparam int unsigned SRC_XLATE_FAULT  = 14;
  localparam int unsigned SRC_FETCH_DONE   = 15;

endpackage

// File: rtl/dispirq_decode.sv
module dispirq_decode
  import dispirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output reg_sel_e          sel,
  output logic              en_wr,
  output logic              ack_wr,
  output logic [HALF_W-1:0] wr_mask,
  output logic [HALF_W-1:0] wr_val
);

  always_comb begin
    if (addr == ADDR_W'(OFF_ENABLE))      sel = SEL_ENABLE;
    else if (addr == ADDR_W'(OFF_ACK))    sel = SEL_ACK;
    else if (addr == ADDR_W'(OFF_FILT))   sel = SEL_FILT;
    else if (addr == ADDR_W'(OFF_RAW))    sel = SEL_RAW;
    else                                  sel = SEL_NONE;
  end

  assign en_wr   = we && (sel == SEL_ENABLE);
  assign ack_wr  = we && (sel == SEL_ACK);
  assign wr_mask = wdata[DATA_W-1:HALF_W];
  assign wr_val  = wdata[HALF_W-1:0];

endmodule

// File: rtl/dispirq_enable.sv
module dispirq_enable #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] val,
  output logic [NSRC-1:0] en_q
);

  logic [NSRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr) en_d = (en_q & ~mask) | (val & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // R2
  en_unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (((en_q ^ $past(en_q)) & ~$past(mask)) == '0));

  // R2
  en_selected_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (((en_q ^ $past(val)) & $past(mask)) == '0));

  // R9
  en_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));

endmodule

// File: rtl/dispirq_latch.sv
module dispirq_latch #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            ack_wr,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] val,
  output logic [NSRC-1:0] raw_q
);

  logic [NSRC-1:0] kill;
  logic [NSRC-1:0] raw_d;

  assign kill = ack_wr ? (mask & val) : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      if (evt[i])       raw_d[i] = 1'b1;
      else if (kill[i]) raw_d[i] = 1'b0;
      else              raw_d[i] = raw_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q[i] <= 1'b0;
      else        raw_q[i] <= raw_d[i];
    end
  end

  // R4 R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && ((mask & val & ~evt) != '0))
      |=> ((raw_q & $past(mask & val & ~evt)) == '0));

  // R3 R9
  no_ack_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> ((~raw_q & $past(raw_q)) == '0));

endmodule

// File: rtl/dispirq_line.sv
module dispirq_line #(
  parameter int unsigned NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] filt,
  output logic            irq_q
);

  logic irq_d;

  assign irq_d = |filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/dispirq_hub.sv
module dispirq_hub
  import dispirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSRC   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   src_evt,
  output logic              irq_o
);

  localparam int unsigned HALF_W = DATA_W / 2;

  // Asynchronous assert, release on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  reg_sel_e          sel;
  logic              en_wr;
  logic              ack_wr;
  logic [HALF_W-1:0] wr_mask;
  logic [HALF_W-1:0] wr_val;
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   raw_q;
  logic [NSRC-1:0]   filt;

  dispirq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .sel     (sel),
    .en_wr   (en_wr),
    .ack_wr  (ack_wr),
    .wr_mask (wr_mask),
    .wr_val  (wr_val)
  );

  dispirq_enable #(.NSRC(NSRC)) u_en (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr    (en_wr),
    .mask  (wr_mask[NSRC-1:0]),
    .val   (wr_val[NSRC-1:0]),
    .en_q  (en_q)
  );

  dispirq_latch #(.NSRC(NSRC)) u_lat (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt    (src_evt),
    .ack_wr (ack_wr),
    .mask   (wr_mask[NSRC-1:0]),
    .val    (wr_val[NSRC-1:0]),
    .raw_q  (raw_q)
  );

  assign filt = raw_q & en_q;

  dispirq_line #(.NSRC(NSRC)) u_line (
    .clk   (clk),
    .rst_n (rst_int_n),
    .filt  (filt),
    .irq_q (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_ENABLE, SEL_ACK: reg_rdata[NSRC-1:0] = en_q;
      SEL_FILT:            reg_rdata[NSRC-1:0] = filt;
      SEL_RAW:             reg_rdata[NSRC-1:0] = raw_q;
      default:             reg_rdata = '0;
    endcase
  end

  // R6
  irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((raw_q & en_q) != '0) |=> irq_o);

  // R6
  irq_drops_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((raw_q & en_q) == '0) |=> !irq_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!irq_o && (en_q == '0) && (raw_q == '0)));

  // R8
  upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_rdata[DATA_W-1:HALF_W] == '0));

endmodule

// File: tb/sim_dispirq_hub.sv
module sim_dispirq_hub;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] src_evt;
  logic        irq_o;

  int checks;
  int fails;
  bit done;

  dispirq_hub u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_evt   (src_evt),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {we, addr, wdata, src, expected rdata after edge, expected irq after edge}
  localparam logic [93:0] VEC [NVEC] = '{
    {1'b0, 12'h28C, 32'h0000_0000, 16'h0003, 32'h0000_0003, 1'b0}, // 0  R4
    {1'b0, 12'h288, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0}, // 1  R5
    {1'b1, 12'h280, 32'h0001_0003, 16'h0000, 32'h0000_0001, 1'b0}, // 2  R2
    {1'b0, 12'h288, 32'h0000_0000, 16'h0000, 32'h0000_0001, 1'b1}, // 3  R5 R6
    {1'b1, 12'h280, 32'h00F0_00FF, 16'h0000, 32'h0000_00F1, 1'b1}, // 4  R2
    {1'b0, 12'h284, 32'h0000_0000, 16'h0000, 32'h0000_00F1, 1'b1}, // 5  R8
    {1'b1, 12'h284, 32'h0003_0002, 16'h0000, 32'h0000_00F1, 1'b1}, // 6  R3
    {1'b0, 12'h28C, 32'h0000_0000, 16'h0000, 32'h0000_0001, 1'b1}, // 7  R3
    {1'b1, 12'h284, 32'h0000_0001, 16'h0000, 32'h0000_00F1, 1'b1}, // 8  R3
    {1'b0, 12'h28C, 32'h0000_0000, 16'h0000, 32'h0000_0001, 1'b1}, // 9  R3
    {1'b1, 12'h284, 32'h0001_0001, 16'h0001, 32'h0000_00F1, 1'b1}, // 10 R7
    {1'b0, 12'h28C, 32'h0000_0000, 16'h0000, 32'h0000_0001, 1'b1}, // 11 R7
    {1'b1, 12'h284, 32'h0001_0001, 16'h0000, 32'h0000_00F1, 1'b1}, // 12 R3
    {1'b0, 12'h288, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0}, // 13 R6
    {1'b0, 12'h288, 32'h0000_0000, 16'h0010, 32'h0000_0010, 1'b0}, // 14 R6
    {1'b0, 12'h288, 32'h0000_0000, 16'h0000, 32'h0000_0010, 1'b1}, // 15 R6
    {1'b1, 12'h290, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0000, 1'b1}, // 16 R9
    {1'b0, 12'h280, 32'h0000_0000, 16'h0000, 32'h0000_00F1, 1'b1}, // 17 R9
    {1'b1, 12'h284, 32'hFFFF_0000, 16'h0000, 32'h0000_00F1, 1'b1}, // 18 R3
    {1'b0, 12'h288, 32'h0000_0000, 16'h0000, 32'h0000_0010, 1'b1}, // 19 R3
    {1'b1, 12'h288, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0010, 1'b1}, // 20 R9
    {1'b0, 12'h28C, 32'h0000_0000, 16'h0000, 32'h0000_0010, 1'b1}, // 21 R9
    {1'b1, 12'h280, 32'h0010_0000, 16'h0000, 32'h0000_00E1, 1'b1}, // 22 R2
    {1'b0, 12'h288, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0}, // 23 R6
    {1'b0, 12'h28C, 32'h0000_0000, 16'h0000, 32'h0000_0010, 1'b0}  // 24 R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the following rising edge.
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [15:0] s);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; src_evt = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 12'h000; reg_wdata = '0; src_evt = '0;
    repeat (2) @(negedge clk);
    reg_addr = 12'h280; #1; check("R1 enable", reg_rdata, 32'h0);
    reg_addr = 12'h28C; #1; check("R1 raw", reg_rdata, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; src_evt = '0;
    do_reset();
    reg_addr = 12'h288; #1; check("R1 filt after release", reg_rdata, 32'h0);
    check("R1 irq after release", {31'd0, irq_o}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][93], VEC[i][92:81], VEC[i][80:49], VEC[i][48:33]);
      check($sformatf("vec%0d rdata", i), reg_rdata, VEC[i][32:1]);
      check($sformatf("vec%0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
    end

    // R1: reset in the middle of activity wipes enable and pending bits.
    do_reset();
    step(1'b0, 12'h280, 32'h0, 16'h0);
    check("R1 mid-run enable", reg_rdata, 32'h0);
    check("R1 mid-run irq", {31'd0, irq_o}, 32'h0);

    // R2 R6: top source alone, enabled by a single-bit masked write.
    step(1'b1, 12'h280, 32'h8000_8000, 16'h0000);
    check("R2 top bit enable", reg_rdata, 32'h0000_8000);
    step(1'b0, 12'h288, 32'h0, 16'h8000);
    check("R5 top bit pending", reg_rdata, 32'h0000_8000);
    check("R6 irq not yet", {31'd0, irq_o}, 32'h0);
    step(1'b0, 12'h288, 32'h0, 16'h0000);
    check("R6 irq raised", {31'd0, irq_o}, 32'h1);
    // R3: write back what the filtered view showed, with the same selector.
    step(1'b1, 12'h284, 32'h8000_8000, 16'h0000);
    check("R3 ack writeback", {31'd0, irq_o}, 32'h1);
    step(1'b0, 12'h28C, 32'h0, 16'h0000);
    check("R3 raw cleared", reg_rdata, 32'h0);
    check("R6 irq dropped", {31'd0, irq_o}, 32'h0);

    // R4: all sources at once while only one is enabled.
    step(1'b0, 12'h28C, 32'h0, 16'hFFFF);
    check("R4 all latched", reg_rdata, 32'h0000_FFFF);
    step(1'b0, 12'h288, 32'h0, 16'h0000);
    check("R5 only enabled shown", reg_rdata, 32'h0000_8000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule